// File: doc/BRIEF.md
# Tuning Block Transmitter

This block is the card-side source of the fixed training block that a card returns when the host asks for a tuning block. The host uses the block to find its best sampling point. Each start strobe produces one framed block on the data bus. The frame is a low start bit, a fixed 512-bit pattern, a CRC16 for each active line and a high end bit. The block then stops driving, and the lines rest at the high idle level.

The bus-width input selects the layout. In wide mode all four lines carry 128 pattern bits each, and each line has its own CRC. In narrow mode line 0 alone carries the whole pattern serially with one CRC, and the other three lines stay high. The width is captured when a strobe is accepted. A done pulse marks the end of each frame, so the controller that decoded the command can go on.

Top module: `tune_block_tx`

## Requirements
- R1: While reset is low and after it, with no transfer running, `oe_o` is 0, `dat_o` is 4'hF and `done_o` is 0.
- R2: In wide mode (`bus4_i`=1), the cycle after an accepted strobe drives `dat_o`=4'h0 with `oe_o`=1. This is the start bit on all lines.
- R3: In wide mode the next 128 cycles carry the pattern, one nibble per cycle. Each byte goes high nibble first, then low nibble, and `dat_o[3]` carries the nibble MSB. The 64-byte pattern is made of two halves. The first half is the words FF0FFF00, FFCCC3CC, C33CCCFF, FEFFFEEF, FFDFFFDD, FFFBFFFB, BFFF7FFF and 77F7BDEF, sent in that order and each most significant byte first. The second half is the first half shifted right by one nibble, with F filled in at the top.
- R4: After the payload, each line sends for 16 cycles the CRC16 of its own payload bits, MSB first. The CRC uses polynomial x^16+x^12+x^5+1 and an initial value of zero.
- R5: After the CRC comes one cycle of `dat_o`=4'hF with `oe_o`=1, which is the end bit. In the next cycle `oe_o` is 0 and every undriven cycle shows `dat_o`=4'hF.
- R6: `done_o` is high for exactly one cycle, the cycle right after the end bit, and is low at all other times.
- R7: In narrow mode (`bus4_i`=0), line 0 carries a low start bit, then the 512 pattern bits MSB first, then the CRC16 of those bits MSB first, then a high end bit. `dat_o[3:1]` stay 1 throughout.
- R8: A strobe that arrives while `oe_o` is high is ignored. The frame in progress does not change, and no second frame follows it.
- R9: The width is sampled with the accepted strobe. A change of `bus4_i` during a frame does not affect that frame.
- R10: `oe_o` stays high for exactly 146 cycles in wide mode and 530 cycles in narrow mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe that requests one frame |
| bus4_i | input | 1 | 1 selects four lines, 0 selects line 0 only |
| dat_o | output | 4 | Data line levels |
| oe_o | output | 1 | Drive enable for the data lines |
| done_o | output | 1 | One-cycle pulse after the end bit |

## Verification
The bound checker watches several rules on every cycle. The lines must be high whenever they are not driven. Each frame must open with a low bit on line 0 and close with an all-high bit. Done must be a single pulse that follows the fall of the drive enable. The drive-enable window must have the exact length for the width captured with the accepted strobe. The pattern content, the per-line CRC values and the nibble ordering can only be confirmed by the bench, which compares every bus cycle against a frame it builds independently. The scenarios with a repeated strobe and a width change in mid-frame then show that such inputs leave the frame unchanged.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int LANES     = 4;
  localparam int PAT_BITS  = 512;
  localparam int LANE_BITS = PAT_BITS / LANES;
  localparam int CRC_W     = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam int CNT_W     = $clog2(PAT_BITS);
  localparam int HALF_BITS = PAT_BITS / 2;

  // frame length with drive enable high: start + payload + crc + end
  localparam int FRAME_WIDE   = 1 + LANE_BITS + CRC_W + 1;
  localparam int FRAME_NARROW = 1 + PAT_BITS + CRC_W + 1;

  localparam logic [HALF_BITS-1:0] HALF_A =
    256'hFF0FFF00_FFCCC3CC_C33CCCFF_FEFFFEEF_FFDFFFDD_FFFBFFFB_BFFF7FFF_77F7BDEF;
  // second half is the first half delayed by one nibble, F-filled
  localparam logic [PAT_BITS-1:0] PATTERN = {HALF_A, 4'hF, HALF_A[HALF_BITS-1:4]};

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_CRC,
    PH_END
  } phase_e;
endpackage

// File: rtl/tune_crc_lane.sv
module tune_crc_lane
  import tune_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic feed_i,
  input  logic bit_i,
  input  logic shift_i,
  output logic msb_o
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb    = bit_i ^ crc_q[CRC_W-1];
  assign msb_o = crc_q[CRC_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
    end else if (clr_i) begin
      crc_q <= '0;
    end else if (feed_i) begin
      crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end else if (shift_i) begin
      crc_q <= {crc_q[CRC_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/tune_pattern_mux.sv
module tune_pattern_mux
  import tune_pkg::*;
(
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             bus4_i,
  output logic [LANES-1:0] bits_o
);
  logic [PAT_BITS-1:0] wide_sh;
  logic [PAT_BITS-1:0] narrow_sh;

  assign wide_sh   = PATTERN << (LANES * int'(cnt_i));
  assign narrow_sh = PATTERN << int'(cnt_i);

  always_comb begin
    if (bus4_i) bits_o = wide_sh[PAT_BITS-1 -: LANES];
    else        bits_o = {{(LANES-1){1'b1}}, narrow_sh[PAT_BITS-1]};
  end
endmodule

// File: rtl/tune_seq.sv
module tune_seq
  import tune_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bus4_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bus4_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(LANE_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(PAT_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_CRC    = CNT_W'(CRC_W - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bus4_q;
  logic             done_q;
  logic [CNT_W-1:0] data_last;

  assign data_last = bus4_q ? LAST_WIDE : LAST_NARROW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      bus4_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= (phase_q == PH_END);
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_START;
          bus4_q  <= bus4_i;
          cnt_q   <= '0;
        end
        PH_START: begin
          phase_q <= PH_DATA;
          cnt_q   <= '0;
        end
        PH_DATA: begin
          if (cnt_q == data_last) begin
            phase_q <= PH_CRC;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CRC: begin
          if (cnt_q == LAST_CRC) begin
            phase_q <= PH_END;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_END:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign bus4_o  = bus4_q;
  assign done_o  = done_q;
endmodule

// File: rtl/tune_block_tx.sv
module tune_block_tx
  import tune_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       bus4_i,
  output logic [3:0] dat_o,
  output logic       oe_o,
  output logic       done_o
);
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             bus4_q;
  logic [LANES-1:0] bits;
  logic [LANES-1:0] crc_msb;

  tune_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .bus4_i  (bus4_i),
    .phase_o (phase),
    .cnt_o   (cnt),
    .bus4_o  (bus4_q),
    .done_o  (done_o)
  );

  tune_pattern_mux u_mux (
    .cnt_i  (cnt),
    .bus4_i (bus4_q),
    .bits_o (bits)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tune_crc_lane u_crc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (phase == PH_START),
      .feed_i  (phase == PH_DATA),
      .bit_i   (bits[g]),
      .shift_i (phase == PH_CRC),
      .msb_o   (crc_msb[g])
    );
  end

  assign oe_o = (phase != PH_IDLE);

  always_comb begin
    unique case (phase)
      PH_START: dat_o = bus4_q ? 4'h0 : 4'hE;
      PH_DATA:  dat_o = bits;
      PH_CRC:   dat_o = bus4_q ? crc_msb : {3'b111, crc_msb[0]};
      default:  dat_o = 4'hF;
    endcase
  end
endmodule

// File: rtl/tune_block_tx_chk.sv
module tune_block_tx_chk
  import tune_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       bus4_i,
  input logic [3:0] dat_o,
  input logic       oe_o,
  input logic       done_o
);
  logic [CNT_W:0] len_q;
  logic           mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      mode_q <= 1'b1;
    end else begin
      len_q <= oe_o ? len_q + 1'b1 : '0;
      if (!oe_o && start_i) mode_q <= bus4_i;
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> dat_o == 4'hF); // R1
  AST_FRAME_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> (dat_o[0] == 1'b0) && $past(start_i)); // R2
  AST_FRAME_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> $past(dat_o) == 4'hF); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_PLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == $fell(oe_o)); // R6
  AST_FRAME_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> int'(len_q) == (mode_q ? FRAME_WIDE : FRAME_NARROW)); // R10
  AST_NARROW_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !mode_q) |-> dat_o[3:1] == 3'b111); // R7
endmodule

bind tune_block_tx tune_block_tx_chk chk_i (.*);

// File: tb/tune_block_tx_tb_top.sv
module tune_block_tx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       bus4_i = 1'b1;
  logic [3:0] dat_o;
  logic       oe_o;
  logic       done_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [5:0] exp_q[$];
  string      req_q[$];

  logic [31:0] words [16] = '{
    32'hFF0FFF00, 32'hFFCCC3CC, 32'hC33CCCFF, 32'hFEFFFEEF,
    32'hFFDFFFDD, 32'hFFFBFFFB, 32'hBFFF7FFF, 32'h77F7BDEF,
    32'hFFF0FFF0, 32'h0FFCCC3C, 32'hCC33CCCF, 32'hFFEFFFEE,
    32'hFFFDFFFD, 32'hDFFFBFFF, 32'hBBFFF7FF, 32'hF77F7BDE};
  logic [511:0] pat;

  always #5 clk_i = ~clk_i;

  tune_block_tx dut_i (.*);

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    logic f;
    f = b ^ c[15];
    return {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
  endfunction

  task automatic push(logic [3:0] d, logic oe, logic dn, string r);
    exp_q.push_back({d, oe, dn});
    req_q.push_back(r);
  endtask

  task automatic build(bit wide, string tag);
    logic [15:0] crc [4];
    logic [3:0]  nib;
    for (int i = 0; i < 4; i++) crc[i] = '0;
    if (wide) begin
      push(4'h0, 1, 0, {"R2", tag});
      for (int k = 0; k < 128; k++) begin
        nib = pat[511 - 4*k -: 4];
        for (int i = 0; i < 4; i++) crc[i] = crc_step(crc[i], nib[i]);
        push(nib, 1, 0, {"R3", tag});
      end
      for (int j = 0; j < 16; j++)
        push({crc[3][15-j], crc[2][15-j], crc[1][15-j], crc[0][15-j]}, 1, 0, {"R4", tag});
    end else begin
      push(4'hE, 1, 0, {"R7", tag});
      for (int k = 0; k < 512; k++) begin
        crc[0] = crc_step(crc[0], pat[511-k]);
        push({3'b111, pat[511-k]}, 1, 0, {"R7", tag});
      end
      for (int j = 0; j < 16; j++) push({3'b111, crc[0][15-j]}, 1, 0, {"R7", tag});
    end
    push(4'hF, 1, 0, {"R5", tag});
    push(4'hF, 0, 1, {"R6", tag});
    for (int j = 0; j < 3; j++) push(4'hF, 0, 0, {"R10", tag});
  endtask

  // monitor: pops one expected bus cycle per negedge
  always @(negedge clk_i) begin
    if (exp_q.size() != 0) begin
      logic [5:0] e;
      string      r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      n_chk++;
      if ({dat_o, oe_o, done_o} !== e) begin
        n_fail++;
        $display("FAIL %s: dat/oe/done got %h/%b/%b expected %h/%b/%b",
                 r, dat_o, oe_o, done_o, e[5:2], e[1], e[0]);
      end
    end
  end

  // driver: one frame, with an optional extra strobe (R8) and width flip (R9)
  task automatic run_block(bit wide, int extra_at, bit flip, string tag);
    @(negedge clk_i);
    bus4_i  = wide;
    start_i = 1'b1;
    @(posedge clk_i);
    #1;
    start_i = 1'b0;
    build(wide, tag);
    if (extra_at > 0) begin
      repeat (extra_at) @(negedge clk_i);
      start_i = 1'b1;
      if (flip) bus4_i = ~bus4_i;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait (exp_q.size() == 0);
    bus4_i = wide;
    @(negedge clk_i);
  endtask

  initial begin
    for (int w = 0; w < 16; w++) pat[511 - 32*w -: 32] = words[w];
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    n_chk++;
    if ({dat_o, oe_o, done_o} !== {4'hF, 1'b0, 1'b0}) begin
      n_fail++;
      $display("FAIL R1: dat/oe/done got %h/%b/%b expected f/0/0", dat_o, oe_o, done_o);
    end
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    n_chk++;
    if ({dat_o, oe_o, done_o} !== {4'hF, 1'b0, 1'b0}) begin
      n_fail++;
      $display("FAIL R1: idle after reset got %h/%b/%b expected f/0/0", dat_o, oe_o, done_o);
    end
    run_block(1'b1, 0, 1'b0, "");
    run_block(1'b0, 0, 1'b0, "");
    run_block(1'b1, 40, 1'b0, "/R8");
    run_block(1'b1, 30, 1'b1, "/R9");
    run_block(1'b0, 100, 1'b1, "/R9");
    run_block(1'b1, 145, 1'b0, "/R8");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule